// File: doc/BRIEF.md
# ALU Operation Selector

This block is the second stage of a two-stage instruction decoder. The first stage reduces an opcode to a 2-bit operation class; this block combines that class with the 6-bit function field (instruction bits 5:0) and produces the 4-bit control word that picks the ALU operation.

For the memory-access class and the branch class the operation is fixed and the function field is ignored. For the register class the function field selects one of five operations. Any function code that is not recognised, and the spare class, fall back to a safe default. The block has no storage. The output is a pure function of the two inputs and follows them within the same cycle.

Control word encoding: `0000` AND, `0001` OR, `0010` add, `0110` subtract, `0111` set-on-less-than.

Top module: `aluctl_decoder`

## Requirements
- R1: With class `00` (memory access), the control word is `0010` (add) for every function field value.
- R2: With class `01` (branch on equal), the control word is `0110` (subtract) for every function field value.
- R3: With class `10` (register), function `0x20` gives `0010` (add) and function `0x22` gives `0110` (subtract).
- R4: With class `10`, function `0x24` gives `0000` (AND), `0x25` gives `0001` (OR) and `0x2A` gives `0111` (set-on-less-than).
- R5: With class `10`, any function code other than `0x20`, `0x22`, `0x24`, `0x25` and `0x2A` gives `0000`.
- R6: Class `11` behaves like class `00`: the control word is `0010` for every function field value.
- R7: Bit 3 of the control word is 0 for every input combination.
- R8: For classes `00` and `01`, and for class `10` with one of the five listed function codes, bit 2 of the control word equals class[0] OR (class[1] AND function[1]).
- R9: The block holds no state: the control word depends only on the present inputs and is valid in the same cycle they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_class_i | input | 2 | Operation class from the first decode stage |
| funct_i | input | 6 | Function field, instruction bits 5:0 |
| alu_ctrl_o | output | 4 | ALU control word |

## Verification
Every result is due zero cycles after its stimulus: the path from inputs to control word is purely combinational. The bench applies each of the 256 class and function combinations on a falling clock edge and compares the output against its own table on the following rising edge, half a period later, so that no input change and no sample share an edge. Applying the combinations in sequence also shows that no earlier input leaves a trace in a later result.

// File: rtl/aluctl_pkg.sv
package aluctl_pkg;

    localparam int CLASS_W = 2;
    localparam int FUNCT_W = 6;
    localparam int CTRL_W  = 4;
    localparam int N_RFUNC = 5;

    localparam logic [CLASS_W-1:0] CLS_MEM    = 2'b00;
    localparam logic [CLASS_W-1:0] CLS_BRANCH = 2'b01;
    localparam logic [CLASS_W-1:0] CLS_REG    = 2'b10;
    localparam logic [CLASS_W-1:0] CLS_SPARE  = 2'b11;

    localparam logic [CTRL_W-1:0] OP_AND = 4'b0000;
    localparam logic [CTRL_W-1:0] OP_OR  = 4'b0001;
    localparam logic [CTRL_W-1:0] OP_ADD = 4'b0010;
    localparam logic [CTRL_W-1:0] OP_SUB = 4'b0110;
    localparam logic [CTRL_W-1:0] OP_SLT = 4'b0111;

    // recognised register-class function codes and the operation each picks
    localparam logic [FUNCT_W-1:0] RFUNC_CODE [N_RFUNC] =
        '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    localparam logic [CTRL_W-1:0]  RFUNC_OP   [N_RFUNC] =
        '{OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT};

    typedef struct packed {
        logic [CTRL_W-1:0] op;
        logic              hit;
    } rdec_t;

endpackage

// File: rtl/aluctl_funct_dec.sv
module aluctl_funct_dec
    import aluctl_pkg::*;
(
    input  logic [FUNCT_W-1:0] funct_i,
    output logic [CTRL_W-1:0]  op_o,
    output logic               hit_o
);

    logic [N_RFUNC-1:0] match;
    rdec_t              dec_d;

    generate
        for (genvar g = 0; g < N_RFUNC; g++) begin : g_match
            assign match[g] = (funct_i == RFUNC_CODE[g]);
        end
    endgenerate

    always_comb begin
        dec_d = '0;
        for (int i = 0; i < N_RFUNC; i++) begin
            if (match[i]) begin
                dec_d.op  = dec_d.op | RFUNC_OP[i];
                dec_d.hit = 1'b1;
            end
        end
    end

    assign op_o  = dec_d.op;
    assign hit_o = dec_d.hit;

endmodule

// File: rtl/aluctl_class_sel.sv
module aluctl_class_sel
    import aluctl_pkg::*;
(
    input  logic [CLASS_W-1:0] class_i,
    input  logic [CTRL_W-1:0]  rop_i,
    input  logic               rhit_i,
    output logic [CTRL_W-1:0]  ctrl_o
);

    logic [CTRL_W-1:0] ctrl_d;

    always_comb begin
        unique case (class_i)
            CLS_BRANCH: ctrl_d = OP_SUB;
            CLS_REG:    ctrl_d = rhit_i ? rop_i : OP_AND;
            default:    ctrl_d = OP_ADD;   // memory class and spare class
        endcase
    end

    assign ctrl_o = ctrl_d;

endmodule

// File: rtl/aluctl_decoder.sv
module aluctl_decoder
    import aluctl_pkg::*;
(
    input  logic [1:0] alu_class_i,
    input  logic [5:0] funct_i,
    output logic [3:0] alu_ctrl_o
);

    logic [CTRL_W-1:0] rop_q;
    logic              rhit_q;

    aluctl_funct_dec u_fdec (
        .funct_i (funct_i),
        .op_o    (rop_q),
        .hit_o   (rhit_q)
    );

    aluctl_class_sel u_csel (
        .class_i (alu_class_i),
        .rop_i   (rop_q),
        .rhit_i  (rhit_q),
        .ctrl_o  (alu_ctrl_o)
    );

    // checks on the combined result of the two stages
    always_comb begin
        if (!$isunknown({alu_class_i, funct_i, alu_ctrl_o})) begin
            a_r7_msb_zero: assert (alu_ctrl_o[3] == 1'b0)
                else $error("R7 control bit 3 set");
            if (alu_class_i == CLS_MEM || alu_class_i == CLS_SPARE) begin
                a_r1_r6_fixed_add: assert (alu_ctrl_o == OP_ADD)
                    else $error("R1/R6 add expected");
            end
            if (alu_class_i == CLS_BRANCH) begin
                a_r2_fixed_sub: assert (alu_ctrl_o == OP_SUB)
                    else $error("R2 subtract expected");
            end
            if (alu_class_i == CLS_REG && !rhit_q) begin
                a_r5_unknown_and: assert (alu_ctrl_o == OP_AND)
                    else $error("R5 default expected");
            end
            if (alu_class_i != CLS_SPARE && (alu_class_i != CLS_REG || rhit_q)) begin
                a_r8_bit2_eqn: assert (alu_ctrl_o[2] ==
                                       (alu_class_i[0] | (alu_class_i[1] & funct_i[1])))
                    else $error("R8 bit 2 mismatch");
            end
        end
    end

endmodule

// File: tb/aluctl_decoder_test.sv
`timescale 1ns/1ps
module aluctl_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cls;
    logic [5:0] fn;
    logic [3:0] ctrl;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    aluctl_decoder uut (
        .alu_class_i (cls),
        .funct_i     (fn),
        .alu_ctrl_o  (ctrl)
    );

    function automatic logic [3:0] model(input int c, input int f);
        if (c == 1) return 4'b0110;
        if (c != 2) return 4'b0010;
        case (f)
            32: return 4'b0010;
            34: return 4'b0110;
            36: return 4'b0000;
            37: return 4'b0001;
            42: return 4'b0111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string tag(input int c, input int f);
        if (c == 0) return "R1";
        if (c == 1) return "R2";
        if (c == 3) return "R6";
        if (f == 32 || f == 34) return "R3";
        if (f == 36 || f == 37 || f == 42) return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s class=%0d funct=%02h got=%b exp=%b", req, cls, fn, got, exp);
        end
    endtask

    initial begin
        cls = 2'b00;
        fn  = 6'h00;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R9: output valid right after start-up, from inputs alone
        check("R9", ctrl, 4'b0010);
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 64; f++) begin
                @(negedge clk);
                cls = 2'(c);
                fn  = 6'(f);
                @(posedge clk);
                check(tag(c, f), ctrl, model(c, f));
                check("R7", {3'b000, ctrl[3]}, 4'b0000);
                if (c != 3 && !(c == 2 && model(c, f) == 4'b0000 && f != 36))
                    check("R8", {3'b000, ctrl[2]},
                          {3'b000, (cls[0] | (cls[1] & fn[1]))});
            end
        end
        // R9: return to an earlier input gives its earlier result, no memory
        @(negedge clk); cls = 2'b10; fn = 6'h2A;
        @(posedge clk); check("R9", ctrl, 4'b0111);
        @(negedge clk); cls = 2'b01; fn = 6'h2A;
        @(posedge clk); check("R9", ctrl, 4'b0110);
        @(negedge clk); cls = 2'b10; fn = 6'h2A;
        @(posedge clk); check("R9", ctrl, 4'b0111);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule